// File: doc/BRIEF.md
# Generation-Tagged Completion Ring

This block tracks a circular descriptor ring that a hardware producer fills with completion entries and a consumer drains. There is no shared head pointer. Each slot instead stores one generation bit next to its payload. The producer stamps every entry it writes with its current generation, and that value flips each time the producer's index wraps. The consumer keeps an expected generation that flips each time its own index wraps. The slot at the read index holds a fresh entry exactly when its stored bit matches that expectation.

The ring length is chosen at run time on `cfg_size`, which is sampled while reset is held. It must be a multiple of 32, with a value between 64 and the `MAX_ENTRIES` parameter. The block keeps one slot permanently empty. It reports the free-slot count and raises a warning once more than half of the ring holds unconsumed entries.

Both data interfaces use valid/ready:
- Consumer side: the consumer may hold `rd_ready` high at any time. An entry is taken only in a cycle where `rd_valid` and `rd_ready` are both high.
- Producer side: a hardware producer cannot be stalled. If it asserts `wr_valid` while `wr_ready` is low, the write is discarded and reported as an overrun one cycle later.

Top module: `cpl_gen_ring`

## Requirements
- R1: Reset (synchronous, `rst_n` low) leaves the ring empty. On the first cycle after release, `free_cnt` is N-1, `rd_valid` is 0, `wr_ready` is 1, and `near_full` and `wr_overrun` are both 0.
- R2: When `wr_valid` and `wr_ready` are both high, `wr_data` is stored at the write index. The write index then advances by one, and from N-1 it returns to 0. Entries reach the consumer in the order they were written.
- R3: On the first pass the producer stamps each entry with generation 1. It inverts that stamp every time its index wraps from N-1 to 0.
- R4: `rd_valid` is high exactly when the slot at the read index has a generation bit equal to the consumer's expected generation. While `rd_valid` is high, `rd_data` shows that slot's payload.
- R5: The expected generation starts at 1 and flips whenever the read index wraps from N-1 to 0. After a full lap has been consumed, the stale entries from that lap never show as valid.
- R6: `free_cnt` = (rd > wr ? 0 : N) + rd - wr - 1, so at most N-1 entries are ever outstanding. `wr_ready` is high exactly when `free_cnt` is non-zero.
- R7: A write offered while `wr_ready` is low is dropped: no index, stored bit or count changes. `wr_overrun` is high for the following cycle only.
- R8: `near_full` is high exactly when the number of pending entries (N-1-`free_cnt`) is more than N/2.
- R9: `cfg_size` is a legal N when it is a multiple of 32 and lies in 64..`MAX_ENTRIES`. Any other value makes the ring 64 entries long and sets `cfg_err` until the next reset.
- R10: Asserting `rd_ready` while `rd_valid` is low has no effect on any index or count.
- R11: A write and a pop accepted in the same cycle both take effect, and `free_cnt` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; `cfg_size` is sampled while low |
| cfg_size | input | CNT_W | Requested ring length N |
| wr_valid | input | 1 | Producer offers an entry |
| wr_ready | output | 1 | A free slot exists |
| wr_data | input | DATA_W | Entry payload |
| rd_valid | output | 1 | Slot at read index holds a fresh entry |
| rd_ready | input | 1 | Consumer pops the entry |
| rd_data | output | DATA_W | Payload at read index |
| free_cnt | output | CNT_W | Free slots |
| near_full | output | 1 | More than half of the ring is pending |
| wr_overrun | output | 1 | A write was dropped in the previous cycle |
| cfg_err | output | 1 | Requested ring length was illegal |

## Verification
The hardest situation to reach is a slot that still holds a stale entry from an earlier lap while the consumer's expectation has already moved on. The stale bit must fail the comparison even though it was once valid. To get there, the stimulus drives thousands of cycles of random writes and pops, so both indices wrap many times on 64- and 256-entry rings. It also fills the ring to the one-slot limit and then drains it completely. Runs of overruns and of pops on an empty ring sit between these phases.

// File: rtl/cpl_ring_pkg.sv
package cpl_ring_pkg;
  localparam int unsigned RING_MIN  = 64;
  localparam int unsigned RING_STEP = 32;
  localparam int unsigned RING_CEIL = 8160;

  // Legal ring length: aligned to RING_STEP, between RING_MIN and cap
  function automatic logic size_ok(input logic [31:0] sz, input logic [31:0] cap);
    return (sz >= RING_MIN) && (sz <= cap) && ((sz & (RING_STEP - 1)) == 0);
  endfunction
endpackage

// File: rtl/gen_ring_ptr.sv
module gen_ring_ptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx,
  output logic             gen
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      gen <= 1'b1;
    end else if (adv) begin
      if (idx == last_idx) begin
        idx <= '0;
        gen <= ~gen;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gen_ring_store.sv
module gen_ring_store #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              wgen,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              exp_gen,
  output logic              vld,
  output logic [DATA_W-1:0] rdata
);
  logic              gen_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        gen_q[i] <= 1'b0;
      else if (we && (widx == IDX_W'(i)))
        gen_q[i] <= wgen;
    end
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(i)))
        data_q[i] <= wdata;
    end
  end

  assign vld   = (gen_q[ridx] == exp_gen);
  assign rdata = data_q[ridx];
endmodule

// File: rtl/gen_ring_occupancy.sv
module gen_ring_occupancy #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned CNT_W = 9
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] ring_n,
  output logic [CNT_W-1:0] free_cnt,
  output logic             near_full
);
  logic [CNT_W:0]   base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] pending;

  always_comb begin
    base      = (rd_idx > wr_idx) ? '0 : {1'b0, ring_n};
    sum       = base + (CNT_W+1)'(rd_idx) - (CNT_W+1)'(wr_idx) - (CNT_W+1)'(1);
    free_cnt  = sum[CNT_W-1:0];
    pending   = ring_n - CNT_W'(1) - free_cnt;
    near_full = {pending, 1'b0} > {1'b0, ring_n};
  end
endmodule

// File: rtl/cpl_gen_ring.sv
module cpl_gen_ring
  import cpl_ring_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 256,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDX_W       = $clog2(MAX_ENTRIES),
  parameter int unsigned CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              near_full,
  output logic              wr_overrun,
  output logic              cfg_err
);
  localparam logic [CNT_W-1:0] FALLBACK_N = CNT_W'(RING_MIN);

  logic [CNT_W-1:0] ring_n;
  logic [CNT_W-1:0] n_minus1;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_gen, rd_gen;
  logic             wr_fire, rd_fire;

  // Ring length latched while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (size_ok(32'(cfg_size), 32'(MAX_ENTRIES))) begin
        ring_n  <= cfg_size;
        cfg_err <= 1'b0;
      end else begin
        ring_n  <= FALLBACK_N;
        cfg_err <= 1'b1;
      end
    end
  end

  assign n_minus1 = ring_n - CNT_W'(1);
  assign last_idx = n_minus1[IDX_W-1:0];

  assign wr_fire = wr_valid & wr_ready;
  assign rd_fire = rd_valid & rd_ready;

  gen_ring_ptr #(.IDX_W(IDX_W)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_fire), .last_idx(last_idx),
    .idx(wr_idx), .gen(wr_gen)
  );

  gen_ring_ptr #(.IDX_W(IDX_W)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_fire), .last_idx(last_idx),
    .idx(rd_idx), .gen(rd_gen)
  );

  gen_ring_store #(.DEPTH(MAX_ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .widx(wr_idx), .wgen(wr_gen),
    .wdata(wr_data), .ridx(rd_idx), .exp_gen(rd_gen), .vld(rd_valid),
    .rdata(rd_data)
  );

  gen_ring_occupancy #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_occ (
    .rd_idx(rd_idx), .wr_idx(wr_idx), .ring_n(ring_n),
    .free_cnt(free_cnt), .near_full(near_full)
  );

  assign wr_ready = |free_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_overrun <= 1'b0;
    else        wr_overrun <= wr_valid & ~wr_ready;
  end
endmodule

// File: rtl/cpl_gen_ring_chk.sv
module cpl_gen_ring_chk #(
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  ring_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  free_cnt,
  input logic              wr_overrun
);
  // R6: never more than N-1 outstanding
  a_r6_one_slot_spare: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= ring_n - CNT_W'(1));

  // R4: an empty ring shows nothing valid
  a_r4_empty_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == ring_n - CNT_W'(1)) |-> !rd_valid);

  // R7: refused write is flagged and leaves the ring full
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_overrun);

  a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rd_ready) |=> (free_cnt == '0));

  // R2: a write into an empty ring surfaces next cycle with its payload
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !rd_ready && free_cnt == ring_n - CNT_W'(1))
    |=> (rd_valid && rd_data == $past(wr_data)));

  // R10: pop on empty does nothing
  a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !wr_valid) |=> ($stable(free_cnt) && !rd_valid));

  // R11: simultaneous write and pop keep the count
  a_r11_both_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_valid && rd_ready) |=> $stable(free_cnt));
endmodule

bind cpl_gen_ring cpl_gen_ring_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_n(ring_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .free_cnt(free_cnt),
  .wr_overrun(wr_overrun)
);

// File: tb/cpl_gen_ring_bench.sv
module cpl_gen_ring_bench;
  localparam int MAXN = 256;
  localparam int CW   = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_size = CW'(64);
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [7:0]    rd_data;
  logic [CW-1:0] free_cnt;
  logic          near_full;
  logic          wr_overrun;
  logic          cfg_err;

  always #2.5 clk = ~clk;

  cpl_gen_ring u_cpl_gen_ring (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .free_cnt(free_cnt),
    .near_full(near_full), .wr_overrun(wr_overrun), .cfg_err(cfg_err)
  );

  // Behavioural reference
  int       m_n, m_rd, m_wr;
  bit       m_pg, m_eg, m_ovr, m_cerr;
  bit       m_gen [MAXN];
  bit [7:0] m_dat [MAXN];

  int    vectors = 0;
  int    fails   = 0;
  int    cycles  = 0;
  bit    done    = 1'b0;
  string phase   = "";

  function automatic int m_free();
    return ((m_rd > m_wr) ? 0 : m_n) + m_rd - m_wr - 1;
  endfunction

  function automatic bit m_valid();
    return m_gen[m_rd] == m_eg;
  endfunction

  task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL [%s] %s: got %0d expected %0d", phase, what, got, exp);
    end
  endtask

  task automatic check_all();
    int f;
    f = m_free();
    vectors++;
    cmp("free_cnt R6", 32'(free_cnt), 32'(f));
    cmp("wr_ready R6", 32'(wr_ready), 32'(f != 0));
    cmp("rd_valid R4", 32'(rd_valid), 32'(m_valid()));
    if (m_valid()) cmp("rd_data R2", 32'(rd_data), 32'(m_dat[m_rd]));
    cmp("near_full R8", 32'(near_full), 32'(((m_n - 1 - f) * 2) > m_n));
    cmp("wr_overrun R7", 32'(wr_overrun), 32'(m_ovr));
    cmp("cfg_err R9", 32'(cfg_err), 32'(m_cerr));
  endtask

  task automatic step(input bit wv, input bit [7:0] d, input bit rr);
    bit wacc, pop;
    @(negedge clk);
    check_all();
    wr_valid = wv;
    wr_data  = d;
    rd_ready = rr;
    wacc  = wv && (m_free() != 0);
    pop   = rr && m_valid();
    m_ovr = wv && (m_free() == 0);
    if (wacc) begin
      m_gen[m_wr] = m_pg;
      m_dat[m_wr] = d;
      m_wr++;
      if (m_wr == m_n) begin m_wr = 0; m_pg = ~m_pg; end
    end
    if (pop) begin
      m_rd++;
      if (m_rd == m_n) begin m_rd = 0; m_eg = ~m_eg; end
    end
  endtask

  task automatic do_reset(input int sz);
    @(negedge clk);
    rst_n    = 1'b0;
    cfg_size = CW'(sz);
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    repeat (2) @(negedge clk);
    m_cerr = !(sz >= 64 && sz <= MAXN && (sz % 32) == 0);
    m_n    = m_cerr ? 64 : sz;
    m_rd = 0; m_wr = 0; m_pg = 1'b1; m_eg = 1'b1; m_ovr = 1'b0;
    for (int i = 0; i < MAXN; i++) m_gen[i] = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic random_run(input int n, input int wpct, input int rpct);
    for (int i = 0; i < n; i++)
      step($urandom_range(99) < wpct, 8'($urandom), $urandom_range(99) < rpct);
  endtask

  initial begin
    do_reset(64);
    phase = "R1 reset";
    step(0, 0, 0);

    phase = "R2 R6 R8 fill";
    for (int i = 0; i < 63; i++) step(1, 8'(i + 3), 0);
    phase = "R7 overrun";
    for (int i = 0; i < 4; i++) step(1, 8'hEE, 0);
    step(0, 0, 0);
    phase = "R2 drain";
    for (int i = 0; i < 63; i++) step(0, 0, 1);
    phase = "R10 empty pop";
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    phase = "R3 R5 laps";
    random_run(3000, 60, 50);
    phase = "R5 stale after lap";
    for (int i = 0; i < 80; i++) step(0, 0, 1);
    phase = "R11 concurrent";
    step(1, 8'h11, 0);
    for (int i = 0; i < 200; i++) step(1, 8'(i), 1);
    phase = "R7 R8 heavy";
    random_run(600, 90, 20);

    do_reset(256);
    phase = "R1 R3 R8 large";
    random_run(2000, 55, 45);
    phase = "R8 large fill";
    random_run(400, 95, 5);

    do_reset(100);
    phase = "R9 illegal 100";
    for (int i = 0; i < 70; i++) step(1, 8'(i), 0);
    do_reset(288);
    phase = "R9 illegal 288";
    for (int i = 0; i < 70; i++) step(1, 8'(i), 0);
    do_reset(32);
    phase = "R9 illegal 32";
    random_run(300, 60, 50);
    do_reset(160);
    phase = "R9 legal 160";
    random_run(800, 60, 50);
    step(0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule